// File: doc/BRIEF.md
# Broadcast Message Capture with Interrupt Freeze

This block sits behind a timing receiver that has already decoded the incoming command stream into messages. Each message carries an 8-bit sub-address, an 8-bit data byte and three error flags: single-bit error (already corrected), double-bit error and transmission error. Every accepted byte is stored in a 256-entry dual-port RAM at the location named by its sub-address. The host reads these entries through a separate read port. A 24-bit turn event count from the receiver is latched at every turn marker, so the host can read it with the RAM contents.

The host programs two watch sub-addresses, each with its own 8-bit data mask. When an accepted byte arrives at a watched sub-address and shares at least one set bit with that watcher's mask, the block raises `irq`. The triggering byte is still written. After that, RAM writes stop until the host reads the acknowledge register. That read returns the sub-address and data of the triggering message and releases the freeze. Three saturating 16-bit counters tally the three error kinds. The host clears any one of them by writing to its address.

Top module: `bcast_capture`

## Requirements
- R1: A message with `msg_valid` high, no double-bit flag and no transmission flag, received while `irq` is low, writes its data byte to RAM entry `msg_sub`. Driving `ram_raddr` returns that entry on `ram_rdata` one clock later.
- R2: A cycle with `turn_tick` high copies `turn_count` into the turn register (host address 4). A change of `turn_count` without a tick leaves the register unchanged.
- R3: Host registers at addresses 0 (watch sub-address A), 1 (mask A), 2 (watch sub-address B) and 3 (mask B) are 8 bits wide and written with `host_wdata` when `host_wr` is high. A read with `host_rd` high returns the value zero-extended on `host_rdata` one clock later.
- R4: An accepted message whose sub-address equals watch A (or watch B) and whose data ANDed with mask A (or mask B) is nonzero sets `irq` high from the next clock. A mask of zero never triggers.
- R5: While `irq` is high, no message is written to RAM, and further matching messages do not change the captured trigger.
- R6: Addresses 5, 6 and 7 hold separate 16-bit counts of messages flagged single-bit error, double-bit error and transmission error. Each count increments by one per flagged valid message.
- R7: Each error counter holds at 0xFFFF instead of wrapping.
- R8: A host write to address 5, 6 or 7 clears that counter to zero, whatever the data. A clear wins over an increment in the same cycle.
- R9: A message flagged with a double-bit or transmission error is neither written to RAM nor able to raise `irq`.
- R10: A message flagged only with a single-bit error is written to RAM and can trigger like a clean one.
- R11: A host read of address 8 returns {16'b0, trigger sub-address, trigger data} and drops `irq` from the next clock, which re-enables RAM writes.
- R12: After reset, `irq` is low and all host registers, counters and the turn register read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| msg_valid | input | 1 | Decoded message present this cycle |
| msg_sub | input | 8 | Message sub-address |
| msg_data | input | 8 | Message data byte |
| msg_sbe | input | 1 | Single-bit error flag (corrected) |
| msg_dbe | input | 1 | Double-bit error flag |
| msg_txe | input | 1 | Transmission error flag |
| turn_tick | input | 1 | Start of turn marker |
| turn_count | input | 24 | Turn event count from receiver |
| host_wr | input | 1 | Host register write strobe |
| host_rd | input | 1 | Host register read strobe |
| host_addr | input | 4 | Host register address |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 32 | Host read data, one clock after the read strobe |
| ram_raddr | input | 8 | RAM read address |
| ram_rdata | output | 8 | RAM read data, one clock after the address |
| irq | output | 1 | Interrupt request; high while RAM is frozen |

## Verification
The bench targets the freeze window. A matching message sent while `irq` is high must leave both the RAM entry and the captured trigger untouched. A design that kept writing would show the newer byte in RAM or in the acknowledge read. Rejected messages at a watched sub-address with matching bits must neither land in RAM nor raise `irq`, and a zero mask must never fire. A design that forgot either check would show a stray interrupt. The single-bit error counter is driven past 65535 events to catch wrap-around, then cleared while the other counters are checked for independence.

// File: rtl/bcp_pkg.sv
// Package: shared widths and the host register map for the message capture block.
// Assumes: host addresses are 4 bits; unlisted addresses read as zero.
package bcp_pkg;
    localparam int SUB_W  = 8;
    localparam int DATA_W = 8;
    localparam int TURN_W = 24;
    localparam int CNT_W  = 16;
    localparam int HAW    = 4;
    localparam int HDW    = 32;
    localparam int N_SEL  = 2;
    localparam int N_ERR  = 3;

    typedef enum logic [HAW-1:0] {
        RA_SEL_A  = 4'd0,
        RA_MASK_A = 4'd1,
        RA_SEL_B  = 4'd2,
        RA_MASK_B = 4'd3,
        RA_TURN   = 4'd4,
        RA_CNT_S  = 4'd5,
        RA_CNT_D  = 4'd6,
        RA_CNT_T  = 4'd7,
        RA_ACK    = 4'd8
    } reg_addr_e;
endpackage

// File: rtl/bcp_sat_counter.sv
// Module: saturating event counter with synchronous clear.
// Assumes: clear has priority over increment; holds at all-ones.
module bcp_sat_counter #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         inc,
    input  logic         clr,
    output logic [W-1:0] count
);
    localparam logic [W-1:0] TOP = '1;

    // Count events, stop at the top value, clear on request.
    always_ff @(posedge clk) begin
        if (!rst_n)
            count <= '0;
        else if (clr)
            count <= '0;
        else if (inc && count != TOP)
            count <= count + 1'b1;
    end

    a_r7_saturate: assert property (@(posedge clk) disable iff (!rst_n)
        (count == TOP && !clr) |=> count == TOP);
    a_r8_clear: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> count == '0);
endmodule

// File: rtl/bcp_capture.sv
// Module: RAM write path, watch matching, interrupt and freeze.
// Assumes: the interrupt flag doubles as the write freeze; ack releases it.
module bcp_capture
    import bcp_pkg::*;
#(
    parameter int SW = SUB_W,
    parameter int DW = DATA_W,
    parameter int NS = N_SEL
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  msg_valid,
    input  logic [SW-1:0]         msg_sub,
    input  logic [DW-1:0]         msg_data,
    input  logic                  reject,
    input  logic [NS-1:0][SW-1:0] watch_sub,
    input  logic [NS-1:0][DW-1:0] watch_mask,
    input  logic                  ack,
    input  logic [SW-1:0]         ram_raddr,
    output logic [DW-1:0]         ram_rdata,
    output logic                  irq,
    output logic [SW-1:0]         trig_sub,
    output logic [DW-1:0]         trig_data
);
    localparam int DEPTH = 1 << SW;

    logic [DW-1:0] mem [DEPTH];
    logic [NS-1:0] hit_vec;
    logic          wr_en;
    logic          set_irq;

    // One match detector per watcher.
    for (genvar g = 0; g < NS; g++) begin : g_watch
        assign hit_vec[g] = (msg_sub == watch_sub[g]) && ((msg_data & watch_mask[g]) != '0);
    end

    assign wr_en   = msg_valid && !reject && !irq;
    assign set_irq = wr_en && (hit_vec != '0);

    // RAM write port: store accepted bytes at their sub-address.
    always_ff @(posedge clk) begin
        if (wr_en)
            mem[msg_sub] <= msg_data;
    end

    // RAM read port: registered host read.
    always_ff @(posedge clk) begin
        ram_rdata <= mem[ram_raddr];
    end

    // Interrupt and freeze flag: set on a match, cleared by ack.
    always_ff @(posedge clk) begin
        if (!rst_n)
            irq <= 1'b0;
        else
            irq <= set_irq | (irq & ~ack);
    end

    // Capture the message that raised the interrupt.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            trig_sub  <= '0;
            trig_data <= '0;
        end else if (set_irq) begin
            trig_sub  <= msg_sub;
            trig_data <= msg_data;
        end
    end

    a_r4_irq_on_match: assert property (@(posedge clk) disable iff (!rst_n)
        (msg_valid && !reject && !irq && (hit_vec != '0)) |=> irq);
    a_r5_hold_trigger: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !ack) |=> (irq && $stable(trig_sub) && $stable(trig_data)));
    a_r9_reject_no_irq: assert property (@(posedge clk) disable iff (!rst_n)
        (msg_valid && reject && !irq) |=> !irq);
    a_r11_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && irq) |=> !irq);
endmodule

// File: rtl/bcp_regs.sv
// Module: host register file, turn latch and registered read mux.
// Assumes: one access per cycle; counter writes only clear; ack is a read side effect.
module bcp_regs
    import bcp_pkg::*;
#(
    parameter int NS = N_SEL,
    parameter int NE = N_ERR
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     host_wr,
    input  logic                     host_rd,
    input  logic [HAW-1:0]           host_addr,
    input  logic [DATA_W-1:0]        host_wdata,
    output logic [HDW-1:0]           host_rdata,
    input  logic                     turn_tick,
    input  logic [TURN_W-1:0]        turn_count,
    input  logic [NE-1:0][CNT_W-1:0] err_count,
    input  logic [SUB_W-1:0]         trig_sub,
    input  logic [DATA_W-1:0]        trig_data,
    output logic [NS-1:0][SUB_W-1:0] watch_sub,
    output logic [NS-1:0][DATA_W-1:0] watch_mask,
    output logic [NE-1:0]            err_clr,
    output logic                     ack
);
    logic [TURN_W-1:0] turn_q;
    logic [HDW-1:0]    rd_mux;

    // Watch sub-address and mask registers, two addresses per watcher.
    for (genvar g = 0; g < NS; g++) begin : g_wreg
        localparam logic [HAW-1:0] A_SUB  = HAW'(2 * g);
        localparam logic [HAW-1:0] A_MASK = HAW'(2 * g + 1);
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                watch_sub[g]  <= '0;
                watch_mask[g] <= '0;
            end else if (host_wr) begin
                if (host_addr == A_SUB)  watch_sub[g]  <= host_wdata;
                if (host_addr == A_MASK) watch_mask[g] <= host_wdata;
            end
        end
    end

    // Clear strobes for each error counter.
    for (genvar e = 0; e < NE; e++) begin : g_clr
        assign err_clr[e] = host_wr && (host_addr == HAW'(RA_CNT_S + e));
    end

    assign ack = host_rd && (host_addr == RA_ACK);

    // Latch the turn count at each turn marker.
    always_ff @(posedge clk) begin
        if (!rst_n)
            turn_q <= '0;
        else if (turn_tick)
            turn_q <= turn_count;
    end

    // Read data selection by address.
    always_comb begin
        rd_mux = '0;
        case (host_addr)
            RA_SEL_A:  rd_mux = HDW'(watch_sub[0]);
            RA_MASK_A: rd_mux = HDW'(watch_mask[0]);
            RA_SEL_B:  rd_mux = HDW'(watch_sub[1]);
            RA_MASK_B: rd_mux = HDW'(watch_mask[1]);
            RA_TURN:   rd_mux = HDW'(turn_q);
            RA_CNT_S:  rd_mux = HDW'(err_count[0]);
            RA_CNT_D:  rd_mux = HDW'(err_count[1]);
            RA_CNT_T:  rd_mux = HDW'(err_count[2]);
            RA_ACK:    rd_mux = HDW'({trig_sub, trig_data});
            default:   rd_mux = '0;
        endcase
    end

    // Register the read data for the host.
    always_ff @(posedge clk) begin
        if (!rst_n)
            host_rdata <= '0;
        else if (host_rd)
            host_rdata <= rd_mux;
    end

    a_r2_turn_latch: assert property (@(posedge clk) disable iff (!rst_n)
        turn_tick |=> turn_q == $past(turn_count));
    a_r2_turn_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !turn_tick |=> $stable(turn_q));
endmodule

// File: rtl/bcast_capture.sv
// Module: top of the broadcast message capture block.
// Assumes: messages arrive already decoded, with at most one per clock.
module bcast_capture
    import bcp_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              msg_valid,
    input  logic [SUB_W-1:0]  msg_sub,
    input  logic [DATA_W-1:0] msg_data,
    input  logic              msg_sbe,
    input  logic              msg_dbe,
    input  logic              msg_txe,
    input  logic              turn_tick,
    input  logic [TURN_W-1:0] turn_count,
    input  logic              host_wr,
    input  logic              host_rd,
    input  logic [HAW-1:0]    host_addr,
    input  logic [DATA_W-1:0] host_wdata,
    output logic [HDW-1:0]    host_rdata,
    input  logic [SUB_W-1:0]  ram_raddr,
    output logic [DATA_W-1:0] ram_rdata,
    output logic              irq
);
    logic [N_SEL-1:0][SUB_W-1:0]  watch_sub;
    logic [N_SEL-1:0][DATA_W-1:0] watch_mask;
    logic [N_ERR-1:0][CNT_W-1:0]  err_count;
    logic [N_ERR-1:0]             err_clr;
    logic [N_ERR-1:0]             err_inc;
    logic [SUB_W-1:0]             trig_sub;
    logic [DATA_W-1:0]            trig_data;
    logic                         ack;

    assign err_inc = {N_ERR{msg_valid}} & {msg_txe, msg_dbe, msg_sbe};

    // One saturating counter per error kind.
    for (genvar e = 0; e < N_ERR; e++) begin : g_err
        bcp_sat_counter #(.W(CNT_W)) u_cnt (
            .clk   (clk),
            .rst_n (rst_n),
            .inc   (err_inc[e]),
            .clr   (err_clr[e]),
            .count (err_count[e])
        );
    end

    bcp_capture u_cap (
        .clk        (clk),
        .rst_n      (rst_n),
        .msg_valid  (msg_valid),
        .msg_sub    (msg_sub),
        .msg_data   (msg_data),
        .reject     (msg_dbe | msg_txe),
        .watch_sub  (watch_sub),
        .watch_mask (watch_mask),
        .ack        (ack),
        .ram_raddr  (ram_raddr),
        .ram_rdata  (ram_rdata),
        .irq        (irq),
        .trig_sub   (trig_sub),
        .trig_data  (trig_data)
    );

    bcp_regs u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .host_wr    (host_wr),
        .host_rd    (host_rd),
        .host_addr  (host_addr),
        .host_wdata (host_wdata),
        .host_rdata (host_rdata),
        .turn_tick  (turn_tick),
        .turn_count (turn_count),
        .err_count  (err_count),
        .trig_sub   (trig_sub),
        .trig_data  (trig_data),
        .watch_sub  (watch_sub),
        .watch_mask (watch_mask),
        .err_clr    (err_clr),
        .ack        (ack)
    );

    a_r12_reset_quiet: assert property (@(posedge clk)
        !rst_n |=> !irq);
endmodule

// File: tb/sim_bcast_capture.sv
module sim_bcast_capture;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        msg_valid = 1'b0;
    logic [7:0]  msg_sub = '0;
    logic [7:0]  msg_data = '0;
    logic        msg_sbe = 1'b0, msg_dbe = 1'b0, msg_txe = 1'b0;
    logic        turn_tick = 1'b0;
    logic [23:0] turn_count = '0;
    logic        host_wr = 1'b0, host_rd = 1'b0;
    logic [3:0]  host_addr = '0;
    logic [7:0]  host_wdata = '0;
    logic [31:0] host_rdata;
    logic [7:0]  ram_raddr = '0;
    logic [7:0]  ram_rdata;
    logic        irq;

    int checks = 0;
    int failures = 0;

    typedef struct {
        logic [31:0] val;
        bit          is_ram;
        string       tag;
    } exp_t;
    exp_t sb_q[$];
    logic pend_h = 1'b0, pend_r = 1'b0, ram_req = 1'b0;

    always #5 clk = ~clk;

    bcast_capture u0 (
        .clk(clk), .rst_n(rst_n), .msg_valid(msg_valid), .msg_sub(msg_sub),
        .msg_data(msg_data), .msg_sbe(msg_sbe), .msg_dbe(msg_dbe), .msg_txe(msg_txe),
        .turn_tick(turn_tick), .turn_count(turn_count), .host_wr(host_wr),
        .host_rd(host_rd), .host_addr(host_addr), .host_wdata(host_wdata),
        .host_rdata(host_rdata), .ram_raddr(ram_raddr), .ram_rdata(ram_rdata), .irq(irq)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Monitor: note which read was issued at the edge, compare at the next falling edge.
    always @(posedge clk) begin
        pend_h <= host_rd;
        pend_r <= ram_req;
    end
    always @(negedge clk) begin
        if (pend_h || pend_r) begin
            if (sb_q.size() == 0) begin
                checks++; failures++;
                $display("FAIL scoreboard empty actual=%h expected=none", host_rdata);
            end else begin
                exp_t e;
                e = sb_q.pop_front();
                check(e.tag, e.is_ram ? {24'b0, ram_rdata} : host_rdata, e.val);
            end
        end
    end

    task automatic host_write(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk); host_wr = 1'b1; host_addr = a; host_wdata = d;
        @(negedge clk); host_wr = 1'b0;
    endtask

    task automatic host_read(input logic [3:0] a, input logic [31:0] exp, input string tag);
        @(negedge clk); host_rd = 1'b1; host_addr = a;
        sb_q.push_back('{exp, 1'b0, tag});
        @(negedge clk); host_rd = 1'b0;
    endtask

    task automatic ram_read(input logic [7:0] a, input logic [7:0] exp, input string tag);
        @(negedge clk); ram_req = 1'b1; ram_raddr = a;
        sb_q.push_back('{{24'b0, exp}, 1'b1, tag});
        @(negedge clk); ram_req = 1'b0;
    endtask

    task automatic send(input logic [7:0] s, input logic [7:0] d, input logic sb,
                        input logic db, input logic tx);
        @(negedge clk);
        msg_valid = 1'b1; msg_sub = s; msg_data = d;
        msg_sbe = sb; msg_dbe = db; msg_txe = tx;
        @(negedge clk);
        msg_valid = 1'b0; msg_sbe = 1'b0; msg_dbe = 1'b0; msg_txe = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++; failures++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        // R12: reset state
        check("R12 irq after reset", {31'b0, irq}, 32'h0);
        host_read(4'd0, 32'h0, "R12 watch A reset");
        host_read(4'd3, 32'h0, "R12 mask B reset");
        host_read(4'd4, 32'h0, "R12 turn reset");
        host_read(4'd5, 32'h0, "R12 sbe count reset");
        host_read(4'd7, 32'h0, "R12 txe count reset");

        // R3: program watchers
        host_write(4'd0, 8'h10); host_write(4'd1, 8'h81);
        host_write(4'd2, 8'h20); host_write(4'd3, 8'h0F);
        host_read(4'd0, 32'h10, "R3 watch A");
        host_read(4'd1, 32'h81, "R3 mask A");
        host_read(4'd2, 32'h20, "R3 watch B");
        host_read(4'd3, 32'h0F, "R3 mask B");

        // R1: clean writes, non-matching data at watched addresses
        send(8'h05, 8'hAA, 0, 0, 0);
        send(8'h10, 8'h7E, 0, 0, 0);
        send(8'h20, 8'hF0, 0, 0, 0);
        check("R4 no common bits no irq", {31'b0, irq}, 32'h0);
        ram_read(8'h05, 8'hAA, "R1 ram 05");
        ram_read(8'h10, 8'h7E, "R1 ram 10");
        ram_read(8'h20, 8'hF0, "R1 ram 20");

        // R2: turn latch
        @(negedge clk); turn_count = 24'h123456; turn_tick = 1'b1;
        @(negedge clk); turn_tick = 1'b0; turn_count = 24'hABCDEF;
        host_read(4'd4, 32'h00123456, "R2 turn latched");
        host_read(4'd4, 32'h00123456, "R2 turn held without tick");

        // R10: single-bit error messages are stored
        send(8'h06, 8'h11, 1, 0, 0);
        ram_read(8'h06, 8'h11, "R10 sbe message stored");
        // R9: rejected messages
        send(8'h07, 8'h33, 0, 0, 0);
        send(8'h07, 8'h22, 0, 1, 0);
        send(8'h07, 8'h44, 0, 0, 1);
        ram_read(8'h07, 8'h33, "R9 rejected not stored");
        send(8'h20, 8'h0F, 0, 1, 0);
        check("R9 rejected no irq", {31'b0, irq}, 32'h0);
        host_read(4'd5, 32'h1, "R6 sbe count");
        host_read(4'd6, 32'h2, "R6 dbe count");
        host_read(4'd7, 32'h1, "R6 txe count");

        // R4/R5/R11: trigger through watcher B, then freeze
        send(8'h20, 8'h01, 0, 0, 0);
        check("R4 irq on watcher B", {31'b0, irq}, 32'h1);
        send(8'h05, 8'h55, 0, 0, 0);
        send(8'h10, 8'h80, 0, 0, 0);
        check("R5 irq held", {31'b0, irq}, 32'h1);
        ram_read(8'h05, 8'hAA, "R5 frozen ram 05");
        ram_read(8'h20, 8'h01, "R5 trigger byte stored");
        host_read(4'd8, 32'h00002001, "R11 ack returns trigger");
        check("R11 irq cleared", {31'b0, irq}, 32'h0);
        ram_read(8'h10, 8'h7E, "R5 frozen ram 10");
        send(8'h05, 8'h55, 0, 0, 0);
        ram_read(8'h05, 8'h55, "R11 writes resumed");

        // R4 via watcher A bit 7; R10 sbe message can trigger
        send(8'h10, 8'h80, 1, 0, 0);
        check("R10 R4 irq watcher A", {31'b0, irq}, 32'h1);
        host_read(4'd8, 32'h00001080, "R11 ack watcher A");
        check("R11 irq cleared again", {31'b0, irq}, 32'h0);

        // R4: zero mask never triggers
        host_write(4'd0, 8'h30); host_write(4'd1, 8'h00);
        send(8'h30, 8'hFF, 0, 0, 0);
        check("R4 zero mask no irq", {31'b0, irq}, 32'h0);

        // R7: saturation of the sbe counter
        @(negedge clk);
        msg_valid = 1'b1; msg_sub = 8'h40; msg_data = 8'h01; msg_sbe = 1'b1;
        repeat (65540) @(negedge clk);
        msg_valid = 1'b0; msg_sbe = 1'b0;
        host_read(4'd5, 32'h0000FFFF, "R7 sbe saturated");
        // R8: clear one counter, others untouched
        host_write(4'd5, 8'h5A);
        host_read(4'd5, 32'h0, "R8 sbe cleared");
        host_read(4'd6, 32'h2, "R8 dbe untouched");
        host_write(4'd6, 8'h00);
        host_read(4'd6, 32'h0, "R8 dbe cleared");

        repeat (3) @(negedge clk);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule